// File: doc/BRIEF.md
# Periodic Schedule Span-Node Walker

This block walks a periodic transfer schedule held in memory for one micro-frame at a time. A start pulse latches the schedule base address, the frame index and the micro-frame number. The walker then reads the frame-list entry for that frame and follows typed link pointers from node to node through a single-outstanding memory read port. For every node it reaches, it emits a one-cycle visit strobe. The strobe carries the node's address and type, together with a recovery qualifier that the downstream transfer engine uses to restrict what it executes. When the walker meets a terminated link pointer, it pulses a list-end flag and returns to idle.

Frame-span nodes let a split transaction reach across a frame boundary. Such a node has a normal forward pointer and a second, backward pointer. In the first two micro-frames, a span node whose backward pointer is live works as a bookmark. The walker stores the forward pointer, enters recovery mode and walks the previous frame's branch. When it later meets a span node whose backward pointer is terminated, it leaves recovery mode and resumes from the bookmark. In all other micro-frames, span nodes are plain links. A step limit stops the walk if a malformed, cyclic schedule would otherwise never end.

The controller has five states. IDLE waits for start (transition START). READ_LIST fetches the frame-list entry (transition GOT_LIST to STEP). STEP judges the current pointer: END to IDLE on a terminated pointer, ABORT to IDLE at the step limit, VISIT_SPAN to READ_BACK for a span node, and VISIT_PLAIN to READ_LINK for any other node. READ_BACK fetches a span node's backward word and then either takes RESUME to STEP (a restore met in recovery mode) or takes NEED_LINK to READ_LINK. READ_LINK fetches the forward word and takes ADVANCE back to STEP. On that transition it either follows the forward pointer, or records it and jumps to the backward pointer.

Top module: `fstn_walker`

## Requirements
- R1: A start pulse is only accepted in idle. The walker then requests the frame-list word at byte address list_base + 4 × frame_idx. A start that arrives while the walker is busy has no effect on the walk in progress.
- R2: A link pointer uses bit 0 as its terminate flag and bits 2:1 as its node type: 00 isochronous, 01 queue head, 10 split isochronous, 11 span node. Bits 31:5 hold a 32-byte-aligned node address, and the low five address bits are zero.
- R3: Each non-terminated pointer that the walker reaches produces exactly one single-cycle visit strobe, which carries that node's address and type. A node's forward pointer is the word at the node address. A span node's backward pointer is the word at node address + 4.
- R4: A terminated pointer ends the walk. It produces a one-cycle list-end pulse with no visit, and busy drops on the next cycle. At most one of visit, list-end and step-error is high in any cycle.
- R5: In micro-frames 0 and 1, outside recovery mode, a span node with a live backward pointer (terminate = 0) causes three things. The forward pointer is saved, the walk continues at the backward pointer, and every later visit carries recovery = 1.
- R6: A span node with a terminated backward pointer, met in recovery mode, is visited with recovery = 1. It then clears recovery mode, and the next visit is the saved pointer's node with recovery = 0. The restore node's own forward pointer is not used.
- R7: In micro-frames 2 to 7, a span node with a live backward pointer is followed along its forward pointer, and no visit carries recovery = 1.
- R8: A span node with a terminated backward pointer, met outside recovery mode, is followed along its forward pointer.
- R9: A span node with a live backward pointer, met while already in recovery mode, is followed along its forward pointer. The bookmark is not overwritten.
- R10: At most STEP_LIMIT visits are made per walk. If another node would be visited after that, a one-cycle step-error pulse is raised instead, no visit is made, and the walker returns to idle.
- R11: Once raised, a read request holds its address stable until the cycle in which read-valid is returned.
- R12: After reset the walker is idle: busy, read request, visit, list-end and step-error are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk for the given frame and micro-frame |
| list_base_i | input | 32 | Byte address of the frame list |
| frame_idx_i | input | FIDX_W | Frame-list index |
| uframe_i | input | UF_W | Micro-frame number 0..7 |
| rd_req_o | output | 1 | Read request, held until rd_valid_i |
| rd_addr_o | output | 32 | Byte address of the requested word |
| rd_valid_i | input | 1 | Read data valid, one cycle |
| rd_data_i | input | 32 | Read data word |
| visit_valid_o | output | 1 | Node visit strobe |
| visit_addr_o | output | 32 | Visited node byte address |
| visit_type_o | output | 2 | Visited node type |
| visit_recovery_o | output | 1 | Visit made in recovery mode |
| list_end_o | output | 1 | Terminated pointer reached |
| step_err_o | output | 1 | Step limit reached, walk aborted |
| busy_o | output | 1 | Walk in progress |

## Verification
On every cycle, the assertions check the following: the read handshake holds its address, the first read after a start targets the frame-list entry, and visit, list-end and step-error never overlap. They also check that a recovery visit only occurs in micro-frame 0 or 1, that the step count never exceeds its limit, and that the block stays quiet while idle. The ordering of visits with their recovery qualifiers can only be shown by the bench's directed schedules. That covers the bookmark jump, the resume at the saved pointer, the refusal to nest a second bookmark, and span nodes treated as plain links in later micro-frames. The bench also checks that a start during a walk is ignored and that a self-looping schedule is cut off by the step limit.

// File: rtl/fstn_walk_pkg.sv
package fstn_walk_pkg;

    typedef enum logic [1:0] {
        LT_ISO  = 2'b00,
        LT_QH   = 2'b01,
        LT_SISO = 2'b10,
        LT_SPAN = 2'b11
    } link_type_e;

    typedef struct packed {
        logic [26:0] blk;
        logic [1:0]  rsvd;
        link_type_e  typ;
        logic        term;
    } link_ptr_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ_LIST,
        S_STEP,
        S_READ_BACK,
        S_READ_LINK
    } walk_state_e;

    localparam int unsigned BACK_WORD_OFS = 4;

endpackage

// File: rtl/fstn_link_decode.sv
module fstn_link_decode
    import fstn_walk_pkg::*;
(
    input  logic [31:0] word_i,
    output logic [31:0] node_addr_o,
    output link_type_e  typ_o,
    output logic        term_o,
    output logic        is_span_o
);
    link_ptr_t lp;

    always_comb begin
        lp          = link_ptr_t'(word_i);
        node_addr_o = {lp.blk, 5'b0};
        typ_o       = lp.typ;
        term_o      = lp.term;
        is_span_o   = (lp.typ == LT_SPAN);
    end
endmodule

// File: rtl/fstn_span_classify.sv
module fstn_span_classify #(
    parameter int UF_W         = 3,
    parameter int SAVE_UF_LAST = 1
) (
    input  logic [31:0]     back_word_i,
    input  logic            rec_mode_i,
    input  logic [UF_W-1:0] uframe_i,
    output logic            do_save_o,
    output logic            do_restore_o
);
    localparam logic [UF_W-1:0] UF_LAST = UF_W'(SAVE_UF_LAST);

    logic back_live;

    always_comb begin
        back_live    = ~back_word_i[0];
        do_save_o    = back_live && !rec_mode_i && (uframe_i <= UF_LAST);
        do_restore_o = !back_live && rec_mode_i;
    end
endmodule

// File: rtl/fstn_step_limiter.sv
module fstn_step_limiter #(
    parameter int STEP_LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic inc_i,
    output logic at_limit_o
);
    localparam int CNT_W = $clog2(STEP_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(STEP_LIMIT);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear_i) begin
            cnt <= '0;
        end else if (inc_i) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_limit_o = (cnt == LIMIT_V);

    // R10: the visit count never passes its bound
    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT_V);

    // R10: no increment is requested once the bound is reached
    p_no_inc_at_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        at_limit_o && !clear_i |-> !inc_i);
endmodule

// File: rtl/fstn_walker.sv
module fstn_walker
    import fstn_walk_pkg::*;
#(
    parameter int FIDX_W       = 10,
    parameter int UF_W         = 3,
    parameter int STEP_LIMIT   = 256,
    parameter int SAVE_UF_LAST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       list_base_i,
    input  logic [FIDX_W-1:0] frame_idx_i,
    input  logic [UF_W-1:0]   uframe_i,
    output logic              rd_req_o,
    output logic [31:0]       rd_addr_o,
    input  logic              rd_valid_i,
    input  logic [31:0]       rd_data_i,
    output logic              visit_valid_o,
    output logic [31:0]       visit_addr_o,
    output logic [1:0]        visit_type_o,
    output logic              visit_recovery_o,
    output logic              list_end_o,
    output logic              step_err_o,
    output logic              busy_o
);
    localparam int IDX_PAD = 32 - FIDX_W - 2;
    localparam logic [UF_W-1:0] UF_LAST = UF_W'(SAVE_UF_LAST);

    walk_state_e       state, state_nx;
    logic [31:0]       base_q;
    logic [FIDX_W-1:0] fidx_q;
    logic [UF_W-1:0]   uf_q;
    logic [31:0]       cur_link;
    logic [31:0]       back_link;
    logic [31:0]       saved_link;
    logic              rec_mode;

    logic [31:0]       cur_addr;
    link_type_e        cur_typ;
    logic              cur_term;
    logic              cur_span;
    logic [31:0]       list_addr;
    logic [31:0]       class_word;
    logic              do_save;
    logic              do_restore;
    logic              at_limit;
    logic              start_ok;

    fstn_link_decode u_cur_dec (
        .word_i      (cur_link),
        .node_addr_o (cur_addr),
        .typ_o       (cur_typ),
        .term_o      (cur_term),
        .is_span_o   (cur_span)
    );

    assign class_word = (state == S_READ_BACK) ? rd_data_i : back_link;

    fstn_span_classify #(
        .UF_W         (UF_W),
        .SAVE_UF_LAST (SAVE_UF_LAST)
    ) u_classify (
        .back_word_i  (class_word),
        .rec_mode_i   (rec_mode),
        .uframe_i     (uf_q),
        .do_save_o    (do_save),
        .do_restore_o (do_restore)
    );

    assign start_ok = (state == S_IDLE) && start_i;

    fstn_step_limiter #(
        .STEP_LIMIT (STEP_LIMIT)
    ) u_limiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_ok),
        .inc_i      (visit_valid_o),
        .at_limit_o (at_limit)
    );

    assign list_addr = base_q + {{IDX_PAD{1'b0}}, fidx_q, 2'b00};

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (start_i) state_nx = S_READ_LIST;
            S_READ_LIST: if (rd_valid_i) state_nx = S_STEP;
            S_STEP: begin
                if (cur_term || at_limit) state_nx = S_IDLE;
                else if (cur_span)        state_nx = S_READ_BACK;
                else                      state_nx = S_READ_LINK;
            end
            S_READ_BACK: begin
                if (rd_valid_i) state_nx = do_restore ? S_STEP : S_READ_LINK;
            end
            S_READ_LINK: if (rd_valid_i) state_nx = S_STEP;
            default:     state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q     <= '0;
            fidx_q     <= '0;
            uf_q       <= '0;
            cur_link   <= 32'h1;
            back_link  <= 32'h1;
            saved_link <= 32'h1;
            rec_mode   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start_i) begin
                        base_q   <= list_base_i;
                        fidx_q   <= frame_idx_i;
                        uf_q     <= uframe_i;
                        rec_mode <= 1'b0;
                    end
                end
                S_READ_LIST: begin
                    if (rd_valid_i) cur_link <= rd_data_i;
                end
                S_READ_BACK: begin
                    if (rd_valid_i) begin
                        back_link <= rd_data_i;
                        if (do_restore) begin
                            cur_link <= saved_link;
                            rec_mode <= 1'b0;
                        end
                    end
                end
                S_READ_LINK: begin
                    if (rd_valid_i) begin
                        if (cur_span && do_save) begin
                            saved_link <= rd_data_i;
                            cur_link   <= back_link;
                            rec_mode   <= 1'b1;
                        end else begin
                            cur_link <= rd_data_i;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_req_o         = 1'b0;
        rd_addr_o        = '0;
        visit_valid_o    = 1'b0;
        visit_addr_o     = cur_addr;
        visit_type_o     = cur_typ;
        visit_recovery_o = 1'b0;
        list_end_o       = 1'b0;
        step_err_o       = 1'b0;
        busy_o           = (state != S_IDLE);
        unique case (state)
            S_IDLE: ;
            S_READ_LIST: begin
                rd_req_o  = 1'b1;
                rd_addr_o = list_addr;
            end
            S_STEP: begin
                list_end_o       = cur_term;
                step_err_o       = !cur_term && at_limit;
                visit_valid_o    = !cur_term && !at_limit;
                visit_recovery_o = visit_valid_o && rec_mode;
            end
            S_READ_BACK: begin
                rd_req_o  = 1'b1;
                rd_addr_o = cur_addr + 32'(BACK_WORD_OFS);
            end
            S_READ_LINK: begin
                rd_req_o  = 1'b1;
                rd_addr_o = cur_addr;
            end
            default: ;
        endcase
    end

    // R11: request address held until the data returns
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));

    // R1: the first read of a walk targets the frame-list entry
    p_first_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> rd_req_o &&
            rd_addr_o == $past(list_base_i) + {{IDX_PAD{1'b0}}, $past(frame_idx_i), 2'b00});

    // R4: visit, list end and step error are exclusive
    p_one_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({visit_valid_o, list_end_o, step_err_o}));

    // R4: busy drops right after the list end
    p_end_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        list_end_o |=> !busy_o);

    // R5 / R7: recovery visits only in the early micro-frames
    p_rec_uframe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        visit_valid_o && visit_recovery_o |-> uf_q <= UF_LAST);

    // R12: nothing happens while idle
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_req_o && !visit_valid_o && !list_end_o && !step_err_o);
endmodule

// File: tb/tb_fstn_walker.sv
`timescale 1ns/1ps
module tb_fstn_walker;
    localparam int LIMIT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] list_base_i = 32'h0;
    logic [9:0]  frame_idx_i = '0;
    logic [2:0]  uframe_i = '0;
    logic        rd_req_o;
    logic [31:0] rd_addr_o;
    logic        rd_valid_i = 1'b0;
    logic [31:0] rd_data_i = '0;
    logic        visit_valid_o;
    logic [31:0] visit_addr_o;
    logic [1:0]  visit_type_o;
    logic        visit_recovery_o;
    logic        list_end_o;
    logic        step_err_o;
    logic        busy_o;

    always #2.5 clk = ~clk;

    fstn_walker #(.FIDX_W(10), .UF_W(3), .STEP_LIMIT(LIMIT), .SAVE_UF_LAST(1)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .list_base_i(list_base_i),
        .frame_idx_i(frame_idx_i), .uframe_i(uframe_i), .rd_req_o(rd_req_o),
        .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
        .visit_valid_o(visit_valid_o), .visit_addr_o(visit_addr_o),
        .visit_type_o(visit_type_o), .visit_recovery_o(visit_recovery_o),
        .list_end_o(list_end_o), .step_err_o(step_err_o), .busy_o(busy_o)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [0:255];
    int lat = 0;

    // memory responder: two-cycle latency
    always @(posedge clk) begin
        if (rd_req_o && !rd_valid_i) begin
            if (lat == 1) begin
                rd_valid_i <= 1'b1;
                rd_data_i  <= mem[rd_addr_o[9:2]];
                lat        <= 0;
            end else begin
                lat <= lat + 1;
            end
        end else begin
            rd_valid_i <= 1'b0;
            lat        <= 0;
        end
    end

    // visit log and handshake monitor
    logic [31:0] log_addr [0:63];
    logic [1:0]  log_typ  [0:63];
    logic        log_rec  [0:63];
    int n_vis = 0;
    int n_end = 0;
    int n_err = 0;
    int hs_bad = 0;
    logic        prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;

    always @(negedge clk) begin
        if (visit_valid_o) begin
            if (n_vis < 64) begin
                log_addr[n_vis] = visit_addr_o;
                log_typ[n_vis]  = visit_type_o;
                log_rec[n_vis]  = visit_recovery_o;
            end
            n_vis++;
        end
        if (list_end_o) n_end++;
        if (step_err_o) n_err++;
        if (prev_wait && (!rd_req_o || rd_addr_o != prev_addr)) hs_bad++;
        prev_wait = rd_req_o && !rd_valid_i;
        prev_addr = rd_addr_o;
    end

    function automatic logic [31:0] lnk(input int k, input logic [1:0] t, input logic term);
        return (32'(k) << 5) | (32'(t) << 1) | 32'(term);
    endfunction

    function automatic logic [31:0] na(input int k);
        return 32'(k) << 5;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected visits
    int          e_n;
    logic [31:0] e_addr [0:63];
    logic [1:0]  e_typ  [0:63];
    logic        e_rec  [0:63];

    task automatic expect_visit(input int k, input logic [1:0] t, input logic r);
        e_addr[e_n] = na(k);
        e_typ[e_n]  = t;
        e_rec[e_n]  = r;
        e_n++;
    endtask

    task automatic run_walk(input int fidx, input int uf, input bit poke_busy);
        n_vis = 0; n_end = 0; n_err = 0;
        @(negedge clk);
        frame_idx_i = 10'(fidx);
        uframe_i    = 3'(uf);
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke_busy) begin
            repeat (6) @(negedge clk);
            frame_idx_i = 10'd3;
            start_i     = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        for (int i = 0; i < 3000; i++) begin
            if (!busy_o) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic compare(input string req);
        check(n_vis == e_n, req, "visit count", 32'(n_vis), 32'(e_n));
        for (int i = 0; i < e_n && i < n_vis && i < 64; i++) begin
            check(log_addr[i] == e_addr[i], req, "visit addr", log_addr[i], e_addr[i]);
            check(log_typ[i] == e_typ[i], req, "visit type", 32'(log_typ[i]), 32'(e_typ[i]));
            check(log_rec[i] == e_rec[i], req, "recovery", 32'(log_rec[i]), 32'(e_rec[i]));
        end
    endtask

    task automatic t_reset();
        check(!busy_o && !rd_req_o && !visit_valid_o && !list_end_o && !step_err_o,
              "R12", "idle after reset",
              {27'b0, busy_o, rd_req_o, visit_valid_o, list_end_o, step_err_o}, 32'h0);
    endtask

    task automatic t_plain_frame();
        // R3 / R8 / R2: frame 0, restore node outside recovery
        e_n = 0;
        expect_visit(1, 2'b01, 0); expect_visit(2, 2'b01, 0);
        expect_visit(6, 2'b11, 0); expect_visit(7, 2'b01, 0);
        run_walk(0, 0, 0);
        compare("R3");
        check(n_end == 1, "R4", "list end count", 32'(n_end), 32'd1);
    endtask

    task automatic t_save_restore();
        // R5 / R6: bookmark in micro-frame 0
        e_n = 0;
        expect_visit(3, 2'b00, 0); expect_visit(4, 2'b11, 0);
        expect_visit(2, 2'b01, 1); expect_visit(6, 2'b11, 1);
        expect_visit(5, 2'b01, 0); expect_visit(6, 2'b11, 0);
        expect_visit(7, 2'b01, 0);
        run_walk(1, 0, 0);
        compare("R5");
        check(n_end == 1, "R6", "list end after resume", 32'(n_end), 32'd1);
    endtask

    task automatic t_late_uframe();
        // R7: same frame, micro-frame 3
        e_n = 0;
        expect_visit(3, 2'b00, 0); expect_visit(4, 2'b11, 0);
        expect_visit(5, 2'b01, 0); expect_visit(6, 2'b11, 0);
        expect_visit(7, 2'b01, 0);
        run_walk(1, 3, 0);
        compare("R7");
    endtask

    task automatic t_no_nest();
        // R9: second bookmark inside recovery is a plain link
        e_n = 0;
        expect_visit(8, 2'b11, 0); expect_visit(9, 2'b01, 1);
        expect_visit(11, 2'b11, 1); expect_visit(13, 2'b01, 1);
        expect_visit(6, 2'b11, 1); expect_visit(10, 2'b01, 0);
        run_walk(2, 1, 0);
        compare("R9");
    endtask

    task automatic t_empty();
        // R4: terminated frame-list entry
        e_n = 0;
        run_walk(3, 0, 0);
        check(n_vis == 0, "R4", "no visits", 32'(n_vis), 32'd0);
        check(n_end == 1, "R4", "list end", 32'(n_end), 32'd1);
    endtask

    task automatic t_busy_start();
        // R1: a start during a walk is ignored
        e_n = 0;
        expect_visit(1, 2'b01, 0); expect_visit(2, 2'b01, 0);
        expect_visit(6, 2'b11, 0); expect_visit(7, 2'b01, 0);
        run_walk(0, 0, 1);
        compare("R1");
        check(n_end == 1, "R1", "single list end", 32'(n_end), 32'd1);
    endtask

    task automatic t_loop();
        // R10: self-linked node is cut off at the limit
        run_walk(4, 2, 0);
        check(n_vis == LIMIT, "R10", "visits at limit", 32'(n_vis), 32'(LIMIT));
        check(n_err == 1, "R10", "step error pulse", 32'(n_err), 32'd1);
        check(n_end == 0, "R10", "no list end", 32'(n_end), 32'd0);
        check(!busy_o, "R10", "idle after abort", 32'(busy_o), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h1;
        // frame list at 0
        mem[0] = lnk(1, 2'b01, 0);
        mem[1] = lnk(3, 2'b00, 0);
        mem[2] = lnk(8, 2'b11, 0);
        mem[3] = 32'h1;
        mem[4] = lnk(14, 2'b01, 0);
        // node k word 0 at index 8k, span back word at 8k+1
        mem[8*1]  = lnk(2, 2'b01, 0);
        mem[8*2]  = lnk(6, 2'b11, 0);
        mem[8*3]  = lnk(4, 2'b11, 0);
        mem[8*4]  = lnk(5, 2'b01, 0);  mem[8*4+1]  = lnk(2, 2'b01, 0);
        mem[8*5]  = lnk(6, 2'b11, 0);
        mem[8*6]  = lnk(7, 2'b01, 0);  mem[8*6+1]  = 32'h1;
        mem[8*7]  = 32'h1;
        mem[8*8]  = lnk(10, 2'b01, 0); mem[8*8+1]  = lnk(9, 2'b01, 0);
        mem[8*9]  = lnk(11, 2'b11, 0);
        mem[8*10] = 32'h1;
        mem[8*11] = lnk(13, 2'b01, 0); mem[8*11+1] = lnk(12, 2'b01, 0);
        mem[8*12] = 32'h1;
        mem[8*13] = lnk(6, 2'b11, 0);
        mem[8*14] = lnk(14, 2'b01, 0);

        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_plain_frame();
        t_save_restore();
        t_late_uframe();
        t_no_nest();
        t_empty();
        t_busy_start();
        t_loop();
        check(hs_bad == 0, "R11", "request held until valid", 32'(hs_bad), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule